// File: doc/BRIEF.md
# Low-Power Clock State Controller

This controller moves a processor core between full-speed operation and two low-power clock states when system logic raises a stop request. If a bus cycle is already under way when the request arrives, the controller waits for that cycle to finish. It then gates the core's internal clock and enters a grant state, and it marks the entry with a one-cycle acknowledge. While the request is present, the controller holds off any new bus cycle.

From the grant state, the controller moves to a deeper state once system logic reports that the external input clock has been halted. That halt indication comes from another clock regime, so it passes through a parameterised synchronizer before the state machine acts on it. When the input clock runs again, the controller returns to the grant state. Dropping the request while in the grant state reopens the internal clock and returns the core to normal operation. The block has no streaming data path: every pin is a plain level or strobe sampled on the rising clock edge.

Top module: `lowpower_clk_ctrl`

## Requirements
- R1: A synchronous reset puts the controller in Normal with the internal clock enabled, the acknowledge low, and the bus hold low once the request input is low.
- R2: In Normal, a request with no bus cycle in flight, or with the in-flight cycle signalling done in the same cycle, moves the state to StopGrant at the next edge.
- R3: In Normal, a request while a bus cycle is in flight and not done moves the state to Draining. Draining stays put until the done strobe is seen, and the state becomes StopGrant at the edge that samples it.
- R4: The internal clock enable is high in Normal and Draining and low in StopGrant and StopClock.
- R5: The state output uses the encoding Normal=2'b00, Draining=2'b01, StopGrant=2'b10, StopClock=2'b11.
- R6: The bus hold output is high in any cycle in which the request input is high or the state is not Normal.
- R7: The acknowledge is high for exactly the first cycle of StopGrant entered from Normal or Draining. A return to StopGrant from StopClock does not raise it.
- R8: StopClock is entered only from StopGrant. It is entered at the edge that sees the halt indication after it has passed HALT_SYNC_STAGES flip-flops. In StopGrant, a synchronized halt takes priority over a dropped request.
- R9: In StopClock, a synchronized halt indication that has cleared moves the state back to StopGrant. The request input has no effect in this state.
- R10: In StopGrant with no synchronized halt, a low request moves the state to Normal.
- R11: In Draining, a low request moves the state back to Normal, and this takes priority over the done strobe.
- R12: The done strobe is ignored outside Draining and Normal. The halt indication is ignored in Normal and Draining, where the state does not change because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req_i | input | 1 | Stop request from system logic |
| bus_busy_i | input | 1 | A bus cycle is in flight |
| bus_done_i | input | 1 | Strobe in the final cycle of a bus cycle |
| ext_clk_halted_i | input | 1 | External input clock reported halted (asynchronous) |
| core_clk_en_o | output | 1 | Internal core clock enable |
| grant_ack_o | output | 1 | One-cycle stop-grant acknowledge |
| state_o | output | 2 | Current state encoding |
| bus_hold_o | output | 1 | Blocks new bus cycles from starting |

## Verification
The bench targets a request that lands while a bus cycle is in flight. A design that skips Draining would gate the clock mid-cycle, and one that ignores the done strobe would stay in Draining forever. It pulses the halt indication in Normal and Draining: a design that lets StopClock be reached from any state would jump there early. It also holds the halt for exactly the synchronizer depth, so an off-by-one in that depth shows up as a one-cycle shift. Round trips through StopClock back to StopGrant would expose a repeated acknowledge. Drops of the request in Draining and StopGrant would show a wrong priority between the request and the done or halt inputs.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_NORMAL = 2'b00,
    ST_DRAIN  = 2'b01,
    ST_GRANT  = 2'b10,
    ST_HALT   = 2'b11
  } lpc_state_e;

  function automatic logic clock_running(input lpc_state_e s);
    return (s == ST_NORMAL) || (s == ST_DRAIN);
  endfunction
endpackage

// File: rtl/lpc_halt_sync.sv
module lpc_halt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else if (STAGES == 1) chain_q <= async_i;
        else chain_q <= {chain_q[STAGES-2:0], async_i};
      end
      assign sync_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lpc_state_fsm.sv
module lpc_state_fsm
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic       busy_i,
  input  logic       done_i,
  input  logic       halted_i,
  output lpc_state_e cur_o,
  output lpc_state_e nxt_o
);
  lpc_state_e cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    unique case (cur_q)
      ST_NORMAL: begin
        if (req_i) begin
          if (busy_i && !done_i) nxt = ST_DRAIN;
          else                   nxt = ST_GRANT;
        end
      end
      ST_DRAIN: begin
        if (!req_i)      nxt = ST_NORMAL;
        else if (done_i) nxt = ST_GRANT;
      end
      ST_GRANT: begin
        if (halted_i)    nxt = ST_HALT;
        else if (!req_i) nxt = ST_NORMAL;
      end
      ST_HALT: begin
        if (!halted_i) nxt = ST_GRANT;
      end
      default: nxt = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= ST_NORMAL;
    else     cur_q <= nxt;
  end

  assign cur_o = cur_q;
  assign nxt_o = nxt;
endmodule

// File: rtl/lpc_out_decode.sv
module lpc_out_decode
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  lpc_state_e cur_i,
  input  lpc_state_e nxt_i,
  output logic       clk_en_o,
  output logic       ack_o,
  output logic       hold_o
);
  logic ack_q;
  logic entering_grant;

  assign entering_grant = clock_running(cur_i) && (nxt_i == ST_GRANT);

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= entering_grant;
  end

  assign clk_en_o = clock_running(cur_i);
  assign ack_o    = ack_q;
  assign hold_o   = req_i || (cur_i != ST_NORMAL);
endmodule

// File: rtl/lowpower_clk_ctrl.sv
module lowpower_clk_ctrl
  import lpc_pkg::*;
#(
  parameter int HALT_SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stop_req_i,
  input  logic               bus_busy_i,
  input  logic               bus_done_i,
  input  logic               ext_clk_halted_i,
  output logic               core_clk_en_o,
  output logic               grant_ack_o,
  output logic [STATE_W-1:0] state_o,
  output logic               bus_hold_o
);
  logic       halted_s;
  lpc_state_e cur, nxt;

  lpc_halt_sync #(.STAGES(HALT_SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(ext_clk_halted_i), .sync_o(halted_s)
  );

  lpc_state_fsm u_fsm (
    .clk(clk), .rst(rst), .req_i(stop_req_i), .busy_i(bus_busy_i),
    .done_i(bus_done_i), .halted_i(halted_s), .cur_o(cur), .nxt_o(nxt)
  );

  lpc_out_decode u_out (
    .clk(clk), .rst(rst), .req_i(stop_req_i), .cur_i(cur), .nxt_i(nxt),
    .clk_en_o(core_clk_en_o), .ack_o(grant_ack_o), .hold_o(bus_hold_o)
  );

  assign state_o = cur;
endmodule

// File: rtl/lowpower_clk_ctrl_chk.sv
module lowpower_clk_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       stop_req_i,
  input logic       bus_busy_i,
  input logic       bus_done_i,
  input logic       core_clk_en_o,
  input logic       grant_ack_o,
  input logic [1:0] state_o,
  input logic       bus_hold_o
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (state_o == 2'b00 && core_clk_en_o && !grant_ack_o));

  assert_fast_grant_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && stop_req_i && (!bus_busy_i || bus_done_i)) |=> state_o == 2'b10);

  assert_no_drain_skip_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && stop_req_i && bus_busy_i && !bus_done_i) |=> state_o == 2'b01);

  assert_drain_done_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01 && stop_req_i && bus_done_i) |=> state_o == 2'b10);

  assert_hold_on_req_R6: assert property (@(posedge clk) disable iff (rst)
    stop_req_i |-> bus_hold_o);

  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    grant_ack_o |=> !grant_ack_o);

  assert_ack_in_grant_R7: assert property (@(posedge clk) disable iff (rst)
    grant_ack_o |-> (state_o == 2'b10 && !core_clk_en_o));

  assert_halt_only_from_grant_R8: assert property (@(posedge clk) disable iff (rst)
    (state_o[1] == 1'b0) |=> state_o != 2'b11);

  assert_drain_abort_R11: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01 && !stop_req_i) |=> state_o == 2'b00);
endmodule

bind lowpower_clk_ctrl lowpower_clk_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .stop_req_i(stop_req_i), .bus_busy_i(bus_busy_i),
  .bus_done_i(bus_done_i), .core_clk_en_o(core_clk_en_o),
  .grant_ack_o(grant_ack_o), .state_o(state_o), .bus_hold_o(bus_hold_o)
);

// File: tb/lowpower_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module lowpower_clk_ctrl_tb_top;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst, req, busy, done, halted;
  logic clk_en, ack, hold;
  logic [1:0] state;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lowpower_clk_ctrl #(.HALT_SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .stop_req_i(req), .bus_busy_i(busy),
    .bus_done_i(done), .ext_clk_halted_i(halted), .core_clk_en_o(clk_en),
    .grant_ack_o(ack), .state_o(state), .bus_hold_o(hold)
  );

  // behavioural reference model
  int m_state = 0;
  int m_ack   = 0;
  int m_pipe[$];

  always @(posedge clk) begin
    int hs, nx;
    if (rst) begin
      m_state = 0; m_ack = 0;
      m_pipe.delete();
      for (int i = 0; i < SYNC; i++) m_pipe.push_back(0);
    end else begin
      hs = (SYNC == 0) ? int'(halted) : m_pipe[SYNC-1];
      nx = m_state;
      case (m_state)
        0: if (req) nx = (busy && !done) ? 1 : 2;
        1: if (!req) nx = 0; else if (done) nx = 2;
        2: if (hs != 0) nx = 3; else if (!req) nx = 0;
        default: if (hs == 0) nx = 2;
      endcase
      m_ack = (m_state <= 1 && nx == 2) ? 1 : 0;
      m_state = nx;
      if (SYNC > 0) begin
        m_pipe.push_front(int'(halted));
        void'(m_pipe.pop_back());
      end
    end
  end

  task automatic check(string tag, int got, int exp, string what);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R5", int'(state), m_state, "state");
    check("R4", int'(clk_en), (m_state <= 1) ? 1 : 0, "clock enable");
    check("R7", int'(ack), m_ack, "acknowledge");
    check("R6", int'(hold), (req || m_state != 0) ? 1 : 0, "bus hold");
  endtask

  task automatic step(input logic r, input logic b, input logic d, input logic h);
    @(negedge clk);
    compare_all();
    req = r; busy = b; done = d; halted = h;
  endtask

  task automatic expect_state(string tag, int exp);
    check(tag, int'(state), exp, "state");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1; req = 0; busy = 0; done = 0; halted = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(state), 0, "reset state");
    check("R1", int'(clk_en), 1, "reset clock enable");
    check("R1", int'(ack), 0, "reset ack");
    check("R1", int'(hold), 0, "reset hold");
    rst = 0;
    step(0, 0, 0, 0);

    // R2: request, bus idle -> grant next edge
    step(1, 0, 0, 0);
    step(1, 0, 0, 0); expect_state("R2", 2);
    check("R7", int'(ack), 1, "ack on entry");
    step(1, 0, 0, 0); check("R7", int'(ack), 0, "ack one cycle");
    // R10: drop request
    step(0, 0, 0, 0);
    step(0, 0, 0, 0); expect_state("R10", 0);

    // R3: request during busy bus cycle
    step(1, 1, 0, 0);
    step(1, 1, 0, 1); expect_state("R3", 1);   // halt ignored in Draining (R12)
    step(1, 1, 0, 1); expect_state("R12", 1);
    step(1, 1, 1, 0); expect_state("R3", 1);
    step(1, 0, 0, 0); expect_state("R3", 2);
    // R8: halt held exactly SYNC cycles before reaching StopClock
    step(1, 0, 0, 1);
    for (int i = 0; i < SYNC; i++) begin
      step(1, 0, 0, 1); expect_state("R8", 2);
    end
    step(0, 0, 1, 1); expect_state("R8", 3);
    step(0, 0, 1, 1); expect_state("R9", 3);      // request and done no effect
    step(0, 0, 0, 0);
    for (int i = 0; i < SYNC; i++) begin
      step(1, 0, 0, 0); expect_state("R9", 3);
    end
    step(1, 0, 0, 0); expect_state("R9", 2);
    check("R7", int'(ack), 0, "no ack on return from StopClock");
    step(0, 0, 0, 0);
    step(0, 0, 0, 0); expect_state("R10", 0);

    // R11: abort drain; request drop wins over done
    step(1, 1, 0, 0);
    step(0, 1, 1, 0); expect_state("R11", 1);
    step(0, 0, 0, 0); expect_state("R11", 0);
    check("R7", int'(ack), 0, "no ack on abort");

    // R2: busy with done in same cycle
    step(1, 1, 1, 0);
    step(1, 0, 0, 0); expect_state("R2", 2);
    step(0, 0, 0, 0);
    // R12: halt in Normal ignored
    step(0, 0, 0, 1);
    for (int i = 0; i < SYNC + 2; i++) begin
      step(0, 0, 1, 1); expect_state("R12", 0);
    end
    step(0, 0, 0, 0);
    repeat (SYNC + 1) step(0, 0, 0, 0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
           ($urandom % 10) < ((i / 200) % 2 == 0 ? 2 : 7));
    end
    step(0, 0, 0, 0);
    finish_run();
  end
endmodule